// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls when a memory that pairs every SRAM cell with a nonvolatile shadow copies data between the two. It brings the SRAM image back from the shadow (a recall) when the supply-good input rises after reset, and on a software recall pulse. It copies the SRAM image into the shadow (a store) in three cases: when supply-good falls, when the shared store/busy line is pulled low, or on a software store pulse. Each cycle runs for a fixed number of clock cycles set by a parameter. While a cycle runs, host access to the SRAM is blocked and the data outputs stay in high impedance.

The block keeps a dirty flag that shows whether the SRAM has been written since the last store. A store requested through the shared line copies data only when that flag is set. Whether or not that store ran, the block then holds every SRAM operation off until the line goes high again. During its own store the block pulls the open-drain line low, so that other devices on the same line store with it. The host signals (`ce`, `we`, `oe`) are plain levels, and the block has no streaming interface. `hsb_n` is the resolved level of the wired line and must be synchronous to `clk`.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: During and after reset, with supply-good low, the block is powered down: `busy`, `arr_store`, `arr_recall`, `hsb_pull_low`, `dirty`, `wr_ok` and `dq_oe` are 0 and `standby` is 1.
- R2: A high `pwr_good` while powered down starts a recall one cycle later. `arr_recall` and `busy` stay high for exactly RECALL_CYC cycles, and the block then becomes idle.
- R3: A low `pwr_good` while idle starts a store one cycle later, whether or not the SRAM is dirty. `arr_store` and `busy` stay high for exactly STORE_CYC cycles, and the block then returns to powered down.
- R4: A low `hsb_n` while idle starts a store when `dirty` is 1. When `dirty` is 0 the store is skipped and `arr_store` stays 0.
- R5: After a store requested through the line, or after a skipped one, the block accepts no SRAM write or read (`wr_ok`=0, `dq_oe`=0) and reports `standby`=1 until `hsb_n` is high. It is idle again on the next cycle.
- R6: A `sw_store` pulse while idle runs a STORE_CYC store and returns to idle. A `sw_recall` pulse while idle runs a RECALL_CYC recall and returns to idle. Recalls may be repeated any number of times.
- R7: When several requests arrive in the same idle cycle, the order of priority is: supply-good low, then `hsb_n` low, then `sw_store`, then `sw_recall`.
- R8: `wr_ok` = `ce` & `we` while idle, and 0 otherwise. An accepted write sets `dirty` on the next cycle. The end of a store clears `dirty`.
- R9: `hsb_pull_low` is 1 exactly while a store runs, and 0 during a recall.
- R10: A request that arrives while a store or recall is running is ignored. No further cycle follows the running one.
- R11: `dq_oe` = `ce` & `oe` & !`we` while idle, and 0 during any store or recall.
- R12: `standby` = !`ce` while idle. It is 1 while powered down or held, and 0 during a store or recall even when `ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Digital supply-good indication |
| hsb_n | input | 1 | Resolved level of the shared open-drain store/busy line |
| hsb_pull_low | output | 1 | Enable of the open-drain pull-down on the shared line |
| sw_store | input | 1 | Software store request pulse |
| sw_recall | input | 1 | Software recall request pulse |
| ce | input | 1 | Host chip select, active high |
| we | input | 1 | Host write strobe, active high |
| oe | input | 1 | Host output enable, active high |
| wr_ok | output | 1 | SRAM write accepted this cycle |
| dq_oe | output | 1 | Drive the SRAM data outputs |
| dirty | output | 1 | SRAM written since the last store |
| busy | output | 1 | A store or recall is running |
| arr_store | output | 1 | Copy the SRAM image to the shadow |
| arr_recall | output | 1 | Copy the shadow to the SRAM image |
| standby | output | 1 | Low-power standby state |

## Verification
A request sampled at a rising edge shows on `busy`, `arr_store`, `arr_recall` and `hsb_pull_low` right after that edge. `dirty` changes at the edge after the accepted write, or at the edge that ends the store. `wr_ok`, `dq_oe` and `standby` follow the host inputs within the same cycle. The bench drives its inputs at the falling edge and advances a behavioural model at the rising edge. It compares every output with the model at the next falling edge, so each registered result is checked in the first cycle it is due. Scenario checks then confirm the cycle lengths, priority order, skipped stores and ignored requests.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    NVX_DOWN   = 3'd0,
    NVX_IDLE   = 3'd1,
    NVX_STORE  = 3'd2,
    NVX_RECALL = 3'd3,
    NVX_HOLD   = 3'd4
  } nvx_mode_e;

  typedef enum logic [1:0] {
    NVX_SRC_AUTO = 2'd0,
    NVX_SRC_PIN  = 2'd1,
    NVX_SRC_SW   = 2'd2
  } nvx_src_e;
endpackage

// File: rtl/nvx_timer.sv
module nvx_timer #(
  parameter int STORE_CYC  = 12,
  parameter int RECALL_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_store,
  input  logic load_recall,
  output logic expired
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_store)  cnt_q <= CW'(STORE_CYC - 1);
    else if (load_recall) cnt_q <= CW'(RECALL_CYC - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvx_seq.sv
module nvx_seq
  import nvx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_good,
  input  logic      line_low,
  input  logic      sw_store,
  input  logic      sw_recall,
  input  logic      dirty,
  input  logic      expired,
  output nvx_mode_e mode,
  output logic      load_store,
  output logic      load_recall,
  output logic      store_done
);
  nvx_mode_e mode_q, mode_d;
  nvx_src_e  src_q, src_d;

  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    unique case (mode_q)
      NVX_DOWN: if (pwr_good) mode_d = NVX_RECALL;
      NVX_IDLE: begin
        if (!pwr_good) begin
          mode_d = NVX_STORE;
          src_d  = NVX_SRC_AUTO;
        end else if (line_low) begin
          mode_d = dirty ? NVX_STORE : NVX_HOLD;
          src_d  = NVX_SRC_PIN;
        end else if (sw_store) begin
          mode_d = NVX_STORE;
          src_d  = NVX_SRC_SW;
        end else if (sw_recall) begin
          mode_d = NVX_RECALL;
        end
      end
      NVX_STORE: if (expired) begin
        case (src_q)
          NVX_SRC_PIN:  mode_d = NVX_HOLD;
          NVX_SRC_AUTO: mode_d = NVX_DOWN;
          default:      mode_d = NVX_IDLE;
        endcase
      end
      NVX_RECALL: if (expired) mode_d = NVX_IDLE;
      NVX_HOLD:   if (!line_low) mode_d = NVX_IDLE;
      default:    mode_d = NVX_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= NVX_DOWN;
      src_q  <= NVX_SRC_SW;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
    end
  end

  assign mode        = mode_q;
  assign load_store  = (mode_q != NVX_STORE) && (mode_d == NVX_STORE);
  assign load_recall = (mode_q != NVX_RECALL) && (mode_d == NVX_RECALL);
  assign store_done  = (mode_q == NVX_STORE) && expired;
endmodule

// File: rtl/nvx_host_gate.sv
module nvx_host_gate
  import nvx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  nvx_mode_e mode,
  input  logic      ce,
  input  logic      we,
  input  logic      oe,
  input  logic      store_done,
  output logic      wr_ok,
  output logic      dq_oe,
  output logic      dirty,
  output logic      standby
);
  logic open_q;
  logic dirty_q;

  assign open_q  = (mode == NVX_IDLE);
  assign wr_ok   = open_q && ce && we;
  assign dq_oe   = open_q && ce && oe && !we;
  assign standby = (open_q && !ce) || (mode == NVX_DOWN) || (mode == NVX_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dirty_q <= 1'b0;
    else if (store_done) dirty_q <= 1'b0;
    else if (wr_ok)      dirty_q <= 1'b1;
  end

  assign dirty = dirty_q;
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nvx_pkg::*;
#(
  parameter int STORE_CYC  = 12,
  parameter int RECALL_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic hsb_n,
  output logic hsb_pull_low,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic ce,
  input  logic we,
  input  logic oe,
  output logic wr_ok,
  output logic dq_oe,
  output logic dirty,
  output logic busy,
  output logic arr_store,
  output logic arr_recall,
  output logic standby
);
  nvx_mode_e mode;
  logic load_store, load_recall, store_done, expired, dirty_w;

  nvx_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_store(load_store),
    .load_recall(load_recall), .expired(expired)
  );

  nvx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .line_low(!hsb_n),
    .sw_store(sw_store), .sw_recall(sw_recall), .dirty(dirty_w),
    .expired(expired), .mode(mode), .load_store(load_store),
    .load_recall(load_recall), .store_done(store_done)
  );

  nvx_host_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ce(ce), .we(we), .oe(oe),
    .store_done(store_done), .wr_ok(wr_ok), .dq_oe(dq_oe),
    .dirty(dirty_w), .standby(standby)
  );

  assign dirty        = dirty_w;
  assign arr_store    = (mode == NVX_STORE);
  assign arr_recall   = (mode == NVX_RECALL);
  assign busy         = arr_store || arr_recall;
  assign hsb_pull_low = arr_store;
endmodule

// File: rtl/nvx_checker.sv
module nvx_checker #(
  parameter int STORE_CYC  = 12,
  parameter int RECALL_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic hsb_pull_low,
  input logic wr_ok,
  input logic dq_oe,
  input logic dirty,
  input logic busy,
  input logic arr_store,
  input logic arr_recall,
  input logic standby
);
  int st_run, rc_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_run <= 0;
      rc_run <= 0;
    end else begin
      st_run <= arr_store  ? st_run + 1 : 0;
      rc_run <= arr_recall ? rc_run + 1 : 0;
    end
  end

  AST_STORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_store) |-> st_run == STORE_CYC); // R3
  AST_RECALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_recall) |-> rc_run == RECALL_CYC); // R2
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> dirty); // R8
  AST_STORE_CLEANS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_store) |-> !dirty); // R8
  AST_NO_HOST_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_ok && !dq_oe)); // R11
  AST_AWAKE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby); // R12
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_store, arr_recall})); // R6
  AST_PULL_NOT_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    arr_recall |-> !hsb_pull_low); // R9
endmodule

bind nv_xfer_ctrl nvx_checker #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_nvx_chk (
  .clk(clk), .rst_n(rst_n), .hsb_pull_low(hsb_pull_low), .wr_ok(wr_ok),
  .dq_oe(dq_oe), .dirty(dirty), .busy(busy), .arr_store(arr_store),
  .arr_recall(arr_recall), .standby(standby)
);

// File: tb/nv_xfer_ctrl_test.sv
module nv_xfer_ctrl_test;
  localparam int SC = 12;
  localparam int RC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, ext_low = 1'b0, sw_st = 1'b0, sw_rc = 1'b0;
  logic ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic pull, wr_ok, dq_oe, dirty, busy, a_st, a_rc, stby;
  logic hsb_line;

  assign hsb_line = !(ext_low || pull);

  always #2.5 clk = ~clk;

  nv_xfer_ctrl #(.STORE_CYC(SC), .RECALL_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg), .hsb_n(hsb_line),
    .hsb_pull_low(pull), .sw_store(sw_st), .sw_recall(sw_rc),
    .ce(ce), .we(we), .oe(oe), .wr_ok(wr_ok), .dq_oe(dq_oe),
    .dirty(dirty), .busy(busy), .arr_store(a_st), .arr_recall(a_rc),
    .standby(stby)
  );

  // model: 0 off, 1 open, 2 storing, 3 recalling, 4 held
  int m_mode = 0, m_left = 0, m_why = 0;   // why: 0 power, 1 line, 2 software
  bit m_dirty = 0;
  int checks = 0, fails = 0;
  bit reported = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit open, was_dirty;
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_dirty = 0;
      return;
    end
    open = (m_mode == 1);
    was_dirty = m_dirty;
    if (open && ce && we) m_dirty = 1;
    if (m_mode == 0) begin
      if (pg) begin m_mode = 3; m_left = RC; end
    end else if (m_mode == 1) begin
      if (!pg)          begin m_mode = 2; m_left = SC; m_why = 0; end
      else if (ext_low) begin m_why = 1; if (was_dirty) begin m_mode = 2; m_left = SC; end else m_mode = 4; end
      else if (sw_st)   begin m_mode = 2; m_left = SC; m_why = 2; end
      else if (sw_rc)   begin m_mode = 3; m_left = RC; end
    end else if (m_mode == 2) begin
      m_left--;
      if (m_left == 0) begin
        m_dirty = 0;
        m_mode = (m_why == 1) ? 4 : (m_why == 0) ? 0 : 1;
      end
    end else if (m_mode == 3) begin
      m_left--;
      if (m_left == 0) m_mode = 1;
    end else if (m_mode == 4) begin
      if (!ext_low) m_mode = 1;
    end
  endtask

  task automatic compare();
    bit open;
    open = (m_mode == 1);
    chk("R3 arr_store",     a_st,  m_mode == 2);
    chk("R2 arr_recall",    a_rc,  m_mode == 3);
    chk("R6 busy",          busy,  m_mode == 2 || m_mode == 3);
    chk("R9 hsb_pull_low",  pull,  m_mode == 2);
    chk("R8 dirty",         dirty, m_dirty);
    chk("R8 wr_ok",         wr_ok, open && ce && we);
    chk("R11 dq_oe",        dq_oe, open && ce && oe && !we);
    chk("R12 standby",      stby,  (open && !ce) || m_mode == 0 || m_mode == 4);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset standby", stby, 1);
    rst_n = 1'b1;
    tick(2);
    chk("R1 off after reset", {a_st, a_rc, pull, dirty}, 0);

    // power up -> recall
    pg = 1'b1;
    tick(1);
    pg = 1'b1;
    chk("R2 recall started", a_rc, 1);
    tick(RC);
    chk("R2 recall over", busy, 0);

    // write then read
    ce = 1; we = 1; tick(1);
    chk("R8 write accepted", wr_ok, 1);
    we = 0; oe = 1; tick(1);
    chk("R8 dirty set", dirty, 1);
    chk("R11 read drives", dq_oe, 1);

    // software store, with requests while busy
    sw_st = 1; tick(1); sw_st = 0;
    chk("R6 store started", a_st, 1);
    chk("R11 hiZ in store", dq_oe, 0);
    sw_rc = 1; sw_st = 1; we = 1; tick(2); sw_rc = 0; sw_st = 0; we = 0;
    chk("R10 write ignored in store", wr_ok, 0);
    tick(SC - 2);
    chk("R6 back to idle", busy, 0);
    chk("R8 dirty cleared", dirty, 0);
    tick(2);
    chk("R10 no extra cycle", busy, 0);

    // line request with clean SRAM -> skipped, held
    ext_low = 1; tick(1);
    chk("R4 skipped store", a_st, 0);
    we = 1; tick(3);
    chk("R5 write blocked in hold", wr_ok, 0);
    chk("R5 standby in hold", stby, 1);
    we = 0;
    ext_low = 0; tick(1);
    chk("R5 released", stby, 0);

    // dirty then line request -> store, then hold
    we = 1; tick(1); we = 0; tick(1);
    ext_low = 1; tick(1);
    chk("R4 dirty store runs", a_st, 1);
    chk("R9 line pulled", pull, 1);
    tick(SC + 3);
    chk("R5 hold after store", stby, 1);
    ext_low = 0; tick(2);

    // repeated recalls, deselected
    ce = 0;
    for (int k = 0; k < 3; k++) begin
      sw_rc = 1; tick(1); sw_rc = 0;
      chk("R12 no standby in recall", stby, 0);
      chk("R9 no pull in recall", pull, 0);
      tick(RC + 1);
      chk("R6 recall repeat done", busy, 0);
    end

    // priority: power fail beats line and software
    ce = 1; we = 1; tick(1); we = 0;
    pg = 0; ext_low = 1; sw_st = 1; sw_rc = 1; tick(1);
    sw_st = 0; sw_rc = 0;
    chk("R7 auto store wins", a_st, 1);
    tick(SC);
    chk("R3 off after auto store", stby, 1);
    ext_low = 0; tick(2);
    pg = 1; tick(RC + 2);
    chk("R2 recall after power back", busy, 0);

    // line beats software store/recall
    ext_low = 1; sw_rc = 1; tick(1); sw_rc = 0;
    chk("R7 line beats recall", a_rc, 0);
    ext_low = 0; tick(2);
    // software store beats recall
    sw_st = 1; sw_rc = 1; tick(1); sw_st = 0; sw_rc = 0;
    chk("R7 sw store beats recall", a_st, 1);
    tick(SC + 2);
    finish_run();
  end
endmodule